// File: doc/BRIEF.md
# Byte-Order Converting Bus Bridge Lanes

This block joins a 32-bit CPU data bus whose byte lanes follow big-endian numbering to a 32-bit peripheral bus with little-endian lanes. Each access carries a byte offset inside the word, a size of one, two or four bytes, a direction and a two-bit conversion mode. The bridge works out which peripheral lanes are enabled, which peripheral address is driven and where every data byte travels. On reads it maps the returned bytes back onto the CPU lanes.

Three conversion strategies can be picked per access. The first keeps numeric values intact by moving bytes to different lanes depending on size and offset. The second keeps the address and uses a fixed byte-for-byte lane wiring, so multi-byte values come out byte-reversed. The third leaves the data bits where they are and adjusts the sub-word address instead. The CPU side uses a valid/ready handshake with one access outstanding. The peripheral side holds a registered request until it acknowledges.

Top module: `endian_lane_bridge`

## Requirements
- R1: `cpu_ready` is high only while no access is outstanding. After an access is accepted it stays low through the response cycle, and `cpu_done` pulses for exactly one cycle per accepted access, one cycle before `cpu_ready` returns.
- R2: An access with mode 3, or with size code 3, never reaches the peripheral bus. In the cycle after acceptance `cpu_done` and `cpu_err` are both high and `bus_req` is low.
- R3: A misaligned access (size code 1 at an odd offset, or size code 2 at a nonzero offset) is rejected the same way as in R2.
- R4: Mode 0 (value preserving): the address is unchanged, and the value is placed with its least significant byte on peripheral lane equal to the offset. A one-byte access at offset n uses lane n, a two-byte access at offset 0 uses lanes 1..0 and at offset 2 uses lanes 3..2, and a four-byte value lands unchanged.
- R5: Mode 2 (lane swap): the address is unchanged, and CPU byte at offset k (CPU bits 31-8k..24-8k) always travels on peripheral lane k (bits 8k+7..8k). One-byte data is thus unchanged, two-byte values are byte-exchanged and four-byte values are fully reversed.
- R6: Mode 1 (address swap): four-byte accesses pass bits through unmodified. The low two address bits are XORed with 2 for two-byte and with 3 for one-byte accesses, and the data keeps its natural order (lane of CPU offset k is 3-k).
- R7: For an accepted write, `bus_be` has exactly one bit set for each byte of the access, on the lanes carrying data. `bus_wdata` is zero on all other lanes.
- R8: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_be`, `bus_addr`, `bus_wdata` and `bus_write` hold their values to the next cycle.
- R9: On a read, `bus_rdata` is sampled in the acknowledge cycle and passed through the inverse of the write lane mapping for the active mode. It is presented on `cpu_rdata` with `cpu_done`, and CPU lanes outside the access read as zero.
- R10: After reset `cpu_ready` is high while `bus_req`, `cpu_done` and `cpu_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Bridge can accept an access |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_mode | input | 2 | Conversion mode: 0 value preserving, 1 address swap, 2 lane swap, 3 reserved |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | DW | CPU write data, offset k on bits DW-1-8k downwards |
| cpu_done | output | 1 | Response pulse |
| cpu_err | output | 1 | Response is an error (valid with cpu_done) |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| bus_req | output | 1 | Peripheral request, held until acknowledged |
| bus_write | output | 1 | Peripheral direction |
| bus_addr | output | AW | Peripheral byte address |
| bus_be | output | DW/8 | Peripheral lane enables, bit k = bits 8k+7..8k |
| bus_wdata | output | DW | Peripheral write data |
| bus_ack | input | 1 | Peripheral completion |
| bus_rdata | input | DW | Peripheral read data, sampled with bus_ack |

## Verification
The bench walks every legal offset of every size in all three modes for both directions, because a lane formula that is right for one size often breaks for another. A bridge that mixed up modes 1 and 2 would drive the right lanes with reversed bytes, or the right bytes with an unmodified address. One that forgot the XOR for one-byte accesses would hit the wrong register in address-swap mode. Reads use a return word with distinct bytes on every lane, so a non-inverse mapping or a leak from unused lanes shows up as a wrong `cpu_rdata`. Rejected accesses (reserved mode, size code 3, odd and half-word misalignment) must give an error response without any `bus_req`, and varying acknowledge delays check that the request is held stable rather than re-issued or dropped.

// File: rtl/elb_pkg.sv
package elb_pkg;
  typedef enum logic [1:0] {
    MODE_VALUE  = 2'd0,
    MODE_ADDRSW = 2'd1,
    MODE_LANESW = 2'd2,
    MODE_RSVD   = 2'd3
  } xmode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } st_e;
endpackage

// File: rtl/elb_rst_sync.sv
module elb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/elb_route.sv
module elb_route
  import elb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic [1:0]      mode,
  input  logic [1:0]      size,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   cpu_w,
  input  logic [DW-1:0]   bus_r,
  output logic            bad,
  output logic [DW/8-1:0] be,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   bus_w,
  output logic [DW-1:0]   cpu_r
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  logic [OFFW-1:0]  off;
  logic [OFFW-1:0]  lane [LANES];
  logic [LANES-1:0] hit;
  int               nbytes;

  assign off    = addr[OFFW-1:0];
  assign nbytes = 1 << size;

  // Lane chosen for each CPU byte slot; one instance per slot.
  for (genvar k = 0; k < LANES; k++) begin : g_slot
    int l;
    always_comb begin
      hit[k] = (k >= int'(off)) && (k < int'(off) + nbytes);
      case (xmode_e'(mode))
        MODE_VALUE:  l = 2 * int'(off) + nbytes - 1 - k;
        MODE_ADDRSW: l = LANES - 1 - k;
        default:     l = k;
      endcase
      lane[k] = OFFW'(l);
    end
  end

  always_comb begin
    bus_w = '0;
    be    = '0;
    cpu_r = '0;
    for (int k = 0; k < LANES; k++) begin
      if (hit[k]) begin
        bus_w[8*lane[k] +: 8]    = cpu_w[DW-1-8*k -: 8];
        be[lane[k]]              = 1'b1;
        cpu_r[DW-1-8*k -: 8]     = bus_r[8*lane[k] +: 8];
      end
    end
  end

  always_comb begin
    addr_o = addr;
    if (xmode_e'(mode) == MODE_ADDRSW && nbytes <= LANES)
      addr_o[OFFW-1:0] = off ^ OFFW'(LANES - nbytes);
  end

  assign bad = (xmode_e'(mode) == MODE_RSVD) || (nbytes > LANES) ||
               ((int'(off) & (nbytes - 1)) != 0);
endmodule

// File: rtl/elb_ctrl.sv
module elb_ctrl
  import elb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic            cpu_write,
  input  logic [1:0]      cpu_mode,
  input  logic [1:0]      cpu_size,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            route_bad,
  input  logic [DW/8-1:0] route_be,
  input  logic [AW-1:0]   route_addr,
  input  logic [DW-1:0]   route_w,
  input  logic [DW-1:0]   route_r,
  input  logic            bus_ack,
  output logic            cpu_ready,
  output logic            cpu_done,
  output logic            cpu_err,
  output logic [DW-1:0]   cpu_rdata,
  output logic            bus_req,
  output logic            bus_write,
  output logic [AW-1:0]   bus_addr,
  output logic [DW/8-1:0] bus_be,
  output logic [DW-1:0]   bus_wdata,
  output logic [1:0]      hold_mode,
  output logic [1:0]      hold_size,
  output logic [AW-1:0]   hold_addr
);
  st_e  state_q, state_d;
  logic accept, good_acc, bus_fin;
  logic req_d, done_d, err_d;
  logic rd_en;

  assign accept   = cpu_valid && (state_q == ST_IDLE);
  assign good_acc = accept && !route_bad;
  assign bus_fin  = (state_q == ST_BUS) && bus_ack;
  assign rd_en    = accept || (bus_fin && !bus_write);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept)  state_d = route_bad ? ST_RESP : ST_BUS;
      ST_BUS:  if (bus_ack) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    req_d  = good_acc || (bus_req && !bus_fin);
    done_d = (accept && route_bad) || bus_fin;
    err_d  = accept && route_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bus_req  <= 1'b0;
      cpu_done <= 1'b0;
      cpu_err  <= 1'b0;
    end else begin
      state_q  <= state_d;
      bus_req  <= req_d;
      cpu_done <= done_d;
      cpu_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_mode <= '0;
      hold_size <= '0;
      hold_addr <= '0;
    end else if (accept) begin
      hold_mode <= cpu_mode;
      hold_size <= cpu_size;
      hold_addr <= cpu_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
    end else if (good_acc) begin
      bus_write <= cpu_write;
      bus_addr  <= route_addr;
      bus_be    <= route_be;
      bus_wdata <= cpu_write ? route_w : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cpu_rdata <= '0;
    else if (rd_en) cpu_rdata <= accept ? '0 : route_r;
  end

  assign cpu_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/endian_lane_bridge.sv
module endian_lane_bridge #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  output logic            cpu_ready,
  input  logic            cpu_write,
  input  logic [1:0]      cpu_mode,
  input  logic [1:0]      cpu_size,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_done,
  output logic            cpu_err,
  output logic [DW-1:0]   cpu_rdata,
  output logic            bus_req,
  output logic            bus_write,
  output logic [AW-1:0]   bus_addr,
  output logic [DW/8-1:0] bus_be,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata
);
  localparam int LANES = DW / 8;

  logic             rst_n_s;
  logic [1:0]       hold_mode, hold_size, sel_mode, sel_size;
  logic [AW-1:0]    hold_addr, sel_addr, route_addr;
  logic             route_bad;
  logic [LANES-1:0] route_be;
  logic [DW-1:0]    route_w, route_r;

  // Idle: route the incoming request; busy: route the held one for read return.
  assign sel_mode = cpu_ready ? cpu_mode : hold_mode;
  assign sel_size = cpu_ready ? cpu_size : hold_size;
  assign sel_addr = cpu_ready ? cpu_addr : hold_addr;

  elb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  elb_route #(.DW(DW), .AW(AW)) u_route (
    .mode   (sel_mode),
    .size   (sel_size),
    .addr   (sel_addr),
    .cpu_w  (cpu_wdata),
    .bus_r  (bus_rdata),
    .bad    (route_bad),
    .be     (route_be),
    .addr_o (route_addr),
    .bus_w  (route_w),
    .cpu_r  (route_r)
  );

  elb_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_mode   (cpu_mode),
    .cpu_size   (cpu_size),
    .cpu_addr   (cpu_addr),
    .route_bad  (route_bad),
    .route_be   (route_be),
    .route_addr (route_addr),
    .route_w    (route_w),
    .route_r    (route_r),
    .bus_ack    (bus_ack),
    .cpu_ready  (cpu_ready),
    .cpu_done   (cpu_done),
    .cpu_err    (cpu_err),
    .cpu_rdata  (cpu_rdata),
    .bus_req    (bus_req),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .hold_mode  (hold_mode),
    .hold_size  (hold_size),
    .hold_addr  (hold_addr)
  );
endmodule

// File: rtl/elb_checker.sv
module elb_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic            cpu_ready,
  input logic [1:0]      cpu_mode,
  input logic [1:0]      cpu_size,
  input logic [AW-1:0]   cpu_addr,
  input logic            cpu_done,
  input logic            cpu_err,
  input logic            bus_req,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic [DW/8-1:0] bus_be,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_ack
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready |=> !cpu_ready);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_ready ##1 (!cpu_done && cpu_ready));

  assert_reserved_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && (cpu_mode == 2'd3 || cpu_size == 2'd3)
      |=> cpu_done && cpu_err && !bus_req);

  assert_misaligned_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && cpu_mode != 2'd3 &&
    ((cpu_size == 2'd1 && cpu_addr[0]) || (cpu_size == 2'd2 && cpu_addr[1:0] != 2'd0))
      |=> cpu_done && cpu_err && !bus_req);

  assert_enable_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                 $countones(bus_be) == 4));

  assert_request_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_be) && $stable(bus_addr) &&
                           $stable(bus_wdata) && $stable(bus_write));

  assert_no_error_on_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_done && !bus_req);
endmodule

bind endian_lane_bridge elb_checker #(.DW(DW), .AW(AW)) u_elb_checker (.*);

// File: tb/test_endian_lane_bridge.sv
module test_endian_lane_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_write = 1'b0;
  logic [1:0]  cpu_mode = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        cpu_ready, cpu_done, cpu_err, bus_req, bus_write;
  logic [31:0] cpu_rdata, bus_addr, bus_wdata;
  logic [3:0]  bus_be;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  endian_lane_bridge i_endian_lane_bridge (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_mode(cpu_mode), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_err(cpu_err),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cpu_byte(input logic [31:0] w, input int k);
    return 8'((w >> (8 * (3 - k))) & 32'hFF);
  endfunction

  // Reference: value-based model of one access, checked cycle by cycle.
  task automatic run(input int m, input int sz, input int o, input bit wr,
                     input logic [31:0] cw, input logic [31:0] rr, input int dly);
    int n, base, xr;
    bit ebad;
    logic [63:0] v, mask;
    logic [31:0] ewd, ecr, ead, base_addr;
    logic [3:0]  ebe;
    string tag;
    n = 1 << sz;
    ebad = (m == 3) || (sz == 3) || ((o % n) != 0);
    tag = (m == 0) ? "R4" : (m == 1) ? "R6" : "R5";
    base_addr = 32'h4000_1230 | 32'(o);
    xr = 4 - n;
    base = (m == 1) ? (o ^ xr) : o;
    ead = (m == 1) ? ((base_addr & ~32'h3) | 32'(base)) : base_addr;
    mask = (64'd1 << (8 * n)) - 64'd1;
    v = '0;
    ewd = '0;
    ecr = '0;
    if (!ebad) begin
      for (int i = 0; i < n; i++) v = (v << 8) | 64'(cpu_byte(cw, o + i));
      if (m == 2) begin
        for (int i = 0; i < n; i++) begin
          ewd |= 32'(cpu_byte(cw, o + i)) << (8 * (o + i));
          ecr |= ((rr >> (8 * (o + i))) & 32'hFF) << (8 * (3 - (o + i)));
        end
      end else begin
        ewd = 32'(v << (8 * base));
        ecr = 32'((((64'(rr) >> (8 * base)) & mask)) << (8 * (4 - o - n)));
      end
    end
    ebe = 4'(((1 << n) - 1) << base);

    @(negedge clk);
    chk(cpu_ready === 1'b1, "R1 ready before accept", 32'(cpu_ready), 32'd1);
    cpu_valid = 1'b1; cpu_write = wr; cpu_mode = 2'(m); cpu_size = 2'(sz);
    cpu_addr = base_addr; cpu_wdata = cw;
    @(negedge clk);
    cpu_valid = 1'b0;
    chk(cpu_ready === 1'b0, "R1 busy after accept", 32'(cpu_ready), 32'd0);
    if (ebad) begin
      chk(cpu_done === 1'b1 && cpu_err === 1'b1,
          (m == 3 || sz == 3) ? "R2 error response" : "R3 misaligned error",
          {30'd0, cpu_done, cpu_err}, 32'd3);
      chk(bus_req === 1'b0, "R2 no bus request on reject", 32'(bus_req), 32'd0);
    end else begin
      chk(bus_req === 1'b1, "R8 request raised", 32'(bus_req), 32'd1);
      chk(bus_addr === ead, {tag, " address"}, bus_addr, ead);
      chk(bus_be === ebe, "R7 byte enables", 32'(bus_be), 32'(ebe));
      chk(bus_write === wr, "R8 direction", 32'(bus_write), 32'(wr));
      if (wr) chk(bus_wdata === ewd, {tag, " R7 write lanes"}, bus_wdata, ewd);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(bus_req === 1'b1 && bus_addr === ead && bus_be === ebe &&
            cpu_ready === 1'b0, "R8 held while waiting", bus_addr, ead);
      end
      bus_ack = 1'b1;
      bus_rdata = rr;
      @(negedge clk);
      bus_ack = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
      chk(cpu_done === 1'b1 && cpu_err === 1'b0, "R1 done pulse",
          {30'd0, cpu_done, cpu_err}, 32'd2);
      chk(bus_req === 1'b0, "R8 request dropped after ack", 32'(bus_req), 32'd0);
      if (!wr) chk(cpu_rdata === ecr, {tag, " R9 read return"}, cpu_rdata, ecr);
    end
    @(negedge clk);
    chk(cpu_ready === 1'b1 && cpu_done === 1'b0, "R1 ready again",
        {30'd0, cpu_ready, cpu_done}, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpu_ready === 1'b1 && bus_req === 1'b0 && cpu_done === 1'b0 && cpu_err === 1'b0,
        "R10 reset state", {28'd0, cpu_ready, bus_req, cpu_done, cpu_err}, 32'h8);
    idx = 0;
    for (int m = 0; m < 3; m++)
      for (int sz = 0; sz < 3; sz++)
        for (int o = 0; o < 4; o += (1 << sz))
          for (int wr = 0; wr < 2; wr++) begin
            run(m, sz, o, wr[0], 32'h8142_C3E4 + 32'(idx) * 32'h0305_0709,
                32'h1A2B_3C4D ^ (32'(idx) * 32'h1111_0000), idx % 3);
            idx++;
          end
    // R2: reserved mode and illegal size
    run(3, 0, 0, 1'b1, 32'h1234_5678, 32'h0, 0);
    run(3, 2, 0, 1'b0, 32'h1234_5678, 32'h0, 0);
    run(0, 3, 0, 1'b1, 32'h1234_5678, 32'h0, 0);
    // R3: misaligned half-word and word
    run(2, 1, 1, 1'b1, 32'h1234_5678, 32'h0, 0);
    run(1, 1, 3, 1'b0, 32'h1234_5678, 32'h0, 0);
    run(0, 2, 2, 1'b1, 32'h1234_5678, 32'h0, 0);
    run(1, 2, 1, 1'b0, 32'h1234_5678, 32'h0, 0);
    // Long acknowledge wait
    run(1, 1, 0, 1'b0, 32'h0, 32'hA0B1_C2D3, 6);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule